// File: doc/BRIEF.md
# Quad DAC Serial Register Bank

This block is the digital front end of a four-channel 12-bit converter. It receives 16-bit command words over a three-wire serial port (active-low chip select, serial clock, serial data). An active-low load strobe copies the last shifted word into an input word register. The same strobe routes the word's 12-bit payload to one of four channel code registers, chosen by the word's 2-bit address. The four codes drive the converter's channel outputs.

All pins are sampled by a system clock through two-flop synchronizers. The serial shift clock is the logical OR of chip select and the serial clock, so a chip-select rising edge while the serial clock is low is itself a shift edge.

An active-low clear input forces all four channel codes to zero-scale or to midscale, as chosen by a clear-select pin. The forced value reaches the outputs without waiting for a clock edge. After the clear is released, the channels keep the clear value until the next load strobe. That strobe writes whatever word the input side then holds: the word from before the clear, or a newly shifted one.

Top module: `qdac_serial_bank`

## Requirements
- R1: After reset, all four channel codes read 0x000 and the held word is 0x0000, so a strobe with no prior shifting writes 0x000 to channel 0.
- R2: Each rising edge of (cs_n OR sclk) shifts sdin into a 16-bit shift register, most significant bit first. The first bit of a frame lands in word bit 15.
- R3: Word bits [15:14] are the channel address, bits [13:12] are ignored, and bits [11:0] are the code (bit 11 is the first code bit sent).
- R4: Address 00 selects channel 0, 01 selects channel 1, 10 selects channel 2 and 11 selects channel 3. Channel k is ch_codes[12k+11:12k].
- R5: A falling edge on ldac_n writes the code only to the addressed channel. The other three channels keep their codes.
- R6: While clr_n is low, all channels read 0x000 if clr_sel is 0, or 0x800 if clr_sel is 1. The outputs change at once, without a clock edge.
- R7: A clear issued in the middle of a frame, with cs_n low, does not disturb the shift register or the held word. The frame completes and loads normally.
- R8: After clr_n returns high, the channels keep the clear value until a later load strobe. A load strobe that falls while clr_n is low does not escape the clear. A strobe with no new frame writes the word held from before the clear.
- R9: If cs_n rises while sclk is low, that edge shifts in one extra bit (the current sdin value), and the oldest bit drops out of the 16-bit register.
- R10: Shift edges that occur while ldac_n is low are ignored. A later strobe writes the word that was present before those edges.
- R11: Changing clr_sel while clr_n is high has no effect on any channel.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to sample all pins |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Serial chip select, active low |
| sclk | input | 1 | Serial clock |
| sdin | input | 1 | Serial data, most significant bit first |
| ldac_n | input | 1 | Active-low load strobe |
| clr_n | input | 1 | Active-low clear |
| clr_sel | input | 1 | Clear value select: 0 gives zero-scale, 1 gives midscale |
| ch_codes | output | 48 | Four 12-bit channel codes; channel k is at bits [12k+11:12k] |

## Verification
The load strobe and the clear can hit the channel registers in the same cycle. The bench provokes this by pulsing ldac_n low and back high while clr_n is held low. It then releases the clear and confirms that every channel still reads the clear value, so the clear wins and the strobe is not replayed. A second strobe after the release must then write the held word. Shift edges that arrive during a low load strobe are provoked by running a full frame inside the strobe pulse, and are judged by the code that the next strobe writes.

// File: rtl/qdac_pkg.sv
package qdac_pkg;
  localparam int unsigned DEF_CHANNELS = 4;
  localparam int unsigned DEF_DATA_W   = 12;
  localparam int unsigned DEF_FRAME_W  = 16;
  localparam int unsigned SYNC_STAGES  = 2;

  typedef enum logic {
    CLR_ZERO = 1'b0,
    CLR_MID  = 1'b1
  } clr_mode_e;
endpackage

// File: rtl/qdac_sync.sv
module qdac_sync #(
  parameter int unsigned W      = 1,
  parameter int unsigned STAGES = qdac_pkg::SYNC_STAGES,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stage_q [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stage_q[0] <= RST_VAL;
    else        stage_q[0] <= d;
  end

  for (genvar s = 1; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stage_q[s] <= RST_VAL;
      else        stage_q[s] <= stage_q[s-1];
    end
  end

  assign q = stage_q[STAGES-1];
endmodule

// File: rtl/qdac_shift_port.sv
module qdac_shift_port #(
  parameter int unsigned FRAME_W = qdac_pkg::DEF_FRAME_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cs_n_s,
  input  logic               sclk_s,
  input  logic               sdin_s,
  input  logic               ldac_n_s,
  output logic [FRAME_W-1:0] word_q,
  output logic               load_q
);
  logic               shclk, shclk_prev, shift_rise;
  logic               ldac_prev, ld_fall;
  logic [FRAME_W-1:0] shreg;

  // Combined shift clock: chip select high masks the serial clock
  assign shclk      = cs_n_s | sclk_s;
  assign shift_rise = shclk & ~shclk_prev;
  assign ld_fall    = ldac_prev & ~ldac_n_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shclk_prev <= 1'b1;
      ldac_prev  <= 1'b1;
    end else begin
      shclk_prev <= shclk;
      ldac_prev  <= ldac_n_s;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                      shreg <= '0;
    else if (shift_rise && ldac_n_s) shreg <= {shreg[FRAME_W-2:0], sdin_s};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      word_q <= '0;
      load_q <= 1'b0;
    end else begin
      load_q <= ld_fall;
      if (ld_fall) word_q <= shreg;
    end
  end

  // R10: the shift register is frozen while the strobe is low
  p_ignore_ldac_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !ldac_n_s |=> $stable(shreg));

  // R7: the held word changes only with a load pulse
  p_word_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !load_q ##1 !load_q |-> $stable(word_q));
endmodule

// File: rtl/qdac_chan_bank.sv
module qdac_chan_bank
  import qdac_pkg::*;
#(
  parameter int unsigned CHANNELS = DEF_CHANNELS,
  parameter int unsigned DATA_W   = DEF_DATA_W,
  localparam int unsigned ADDR_W  = $clog2(CHANNELS)
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       wr_valid,
  input  logic [ADDR_W-1:0]          wr_addr,
  input  logic [DATA_W-1:0]          wr_data,
  input  logic                       clr_n_s,
  input  logic                       clr_sel_s,
  output logic [CHANNELS*DATA_W-1:0] codes
);
  localparam logic [DATA_W-1:0] MID_CODE = {1'b1, {(DATA_W-1){1'b0}}};

  clr_mode_e           mode;
  logic [DATA_W-1:0]   clr_val;
  logic [CHANNELS-1:0] wr_en;
  logic [DATA_W-1:0]   code_q [CHANNELS];

  assign mode    = clr_mode_e'(clr_sel_s);
  assign clr_val = (mode == CLR_MID) ? MID_CODE : '0;

  for (genvar i = 0; i < CHANNELS; i++) begin : g_chan
    assign wr_en[i] = wr_valid && (wr_addr == ADDR_W'(i));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        code_q[i] <= '0;
      else if (!clr_n_s) code_q[i] <= clr_val;
      else if (wr_en[i]) code_q[i] <= wr_data;
    end

    assign codes[i*DATA_W +: DATA_W] = code_q[i];

    // R6: a held clear forces the selected value into every channel
    p_clear_force_r6: assert property (@(posedge clk) disable iff (!rst_n)
      !clr_n_s |=> code_q[i] == ($past(clr_sel_s) ? MID_CODE : '0));

    // R8: without a write the channel keeps its value once clear is gone
    p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_n_s && !wr_en[i]) |=> $stable(code_q[i]));

    // R4: a write lands the payload in the channel
    p_write_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_n_s && wr_en[i]) |=> code_q[i] == $past(wr_data));
  end

  // R5: at most one channel is written per strobe
  p_onehot_wr_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(wr_en));
endmodule

// File: rtl/qdac_serial_bank.sv
module qdac_serial_bank
  import qdac_pkg::*;
#(
  parameter int unsigned CHANNELS = DEF_CHANNELS,
  parameter int unsigned DATA_W   = DEF_DATA_W,
  parameter int unsigned FRAME_W  = DEF_FRAME_W
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       cs_n,
  input  logic                       sclk,
  input  logic                       sdin,
  input  logic                       ldac_n,
  input  logic                       clr_n,
  input  logic                       clr_sel,
  output logic [CHANNELS*DATA_W-1:0] ch_codes
);
  localparam int unsigned ADDR_W = $clog2(CHANNELS);
  localparam int unsigned DC_W   = FRAME_W - ADDR_W - DATA_W;
  localparam logic [DATA_W-1:0] MID_CODE = {1'b1, {(DATA_W-1){1'b0}}};

  logic [5:0]                 pins_s;
  logic                       cs_n_s, sclk_s, sdin_s, ldac_n_s, clr_n_s, clr_sel_s;
  logic [FRAME_W-1:0]         word_q;
  logic                       load_q;
  logic [CHANNELS*DATA_W-1:0] bank_codes;
  logic [DATA_W-1:0]          live_clr;

  qdac_sync #(.W(6), .RST_VAL(6'b111110)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     ({cs_n, sclk, sdin, ldac_n, clr_n, clr_sel}),
    .q     (pins_s)
  );
  assign {cs_n_s, sclk_s, sdin_s, ldac_n_s, clr_n_s, clr_sel_s} = pins_s;

  qdac_shift_port #(.FRAME_W(FRAME_W)) u_port (
    .clk      (clk),
    .rst_n    (rst_n),
    .cs_n_s   (cs_n_s),
    .sclk_s   (sclk_s),
    .sdin_s   (sdin_s),
    .ldac_n_s (ldac_n_s),
    .word_q   (word_q),
    .load_q   (load_q)
  );

  if (DC_W > 0) begin : g_dc
    logic dc_unused;
    assign dc_unused = ^word_q[DATA_W +: DC_W];
  end

  qdac_chan_bank #(.CHANNELS(CHANNELS), .DATA_W(DATA_W)) u_bank (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_valid  (load_q),
    .wr_addr   (word_q[FRAME_W-1 -: ADDR_W]),
    .wr_data   (word_q[DATA_W-1:0]),
    .clr_n_s   (clr_n_s),
    .clr_sel_s (clr_sel_s),
    .codes     (bank_codes)
  );

  // Clear reaches the outputs straight from the pins, ahead of the sync
  assign live_clr = clr_sel ? MID_CODE : '0;
  assign ch_codes = clr_n ? bank_codes : {CHANNELS{live_clr}};
endmodule

// File: tb/qdac_serial_bank_tb_top.sv
module qdac_serial_bank_tb_top;
  logic clk = 1'b0, rst_n = 1'b0;
  logic cs_n = 1'b1, sclk = 1'b1, sdin = 1'b0, ldac_n = 1'b1, clr_n = 1'b1, clr_sel = 1'b0;
  logic [47:0] ch_codes;
  int n_chk = 0, n_fail = 0;
  logic done = 1'b0;
  logic [11:0] mdl [4];

  always #10 clk = ~clk;

  qdac_serial_bank dut_i (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sclk(sclk), .sdin(sdin),
    .ldac_n(ldac_n), .clr_n(clr_n), .clr_sel(clr_sel), .ch_codes(ch_codes)
  );

  // {word, expected channel, expected code}
  localparam logic [29:0] VEC [8] = '{
    {16'h0123, 2'd0, 12'h123}, {16'h7456, 2'd1, 12'h456},
    {16'h9ABC, 2'd2, 12'hABC}, {16'hEFFF, 2'd3, 12'hFFF},
    {16'h2800, 2'd0, 12'h800}, {16'h5001, 2'd1, 12'h001},
    {16'hC000, 2'd3, 12'h000}, {16'hB7E5, 2'd2, 12'h7E5}
  };

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check_all(input string req);
    for (int k = 0; k < 4; k++) begin
      n_chk++;
      if (ch_codes[k*12 +: 12] !== mdl[k]) begin
        n_fail++;
        $display("FAIL %s ch%0d actual=%h expected=%h", req, k, ch_codes[k*12 +: 12], mdl[k]);
      end
    end
  endtask

  task automatic set_all(input logic [11:0] v);
    for (int k = 0; k < 4; k++) mdl[k] = v;
  endtask

  task automatic send_bits(input logic [15:0] w, input int nbits, input int first);
    for (int b = first; b > first - nbits; b--) begin
      sclk = 1'b0; sdin = w[b]; wait_n(3);
      sclk = 1'b1; wait_n(3);
    end
  endtask

  task automatic frame(input logic [15:0] w);
    cs_n = 1'b0; wait_n(3);
    send_bits(w, 16, 15);
    cs_n = 1'b1; wait_n(3);
  endtask

  task automatic strobe();
    ldac_n = 1'b0; wait_n(4);
    ldac_n = 1'b1; wait_n(6);
  endtask

  task automatic pulse_clear(input logic sel);
    clr_sel = sel; clr_n = 1'b0; wait_n(5);
    clr_n = 1'b1; wait_n(5);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    logic [15:0] spur;
    set_all(12'h000);
    wait_n(3); rst_n = 1'b1; wait_n(4);
    check_all("R1 reset");

    // Held word after reset is zero: midscale clear, then bare strobe
    pulse_clear(1'b1);
    set_all(12'h800);
    check_all("R8 clear held after release");
    strobe();
    mdl[0] = 12'h000;
    check_all("R1 held word zero");

    // Vector table: R2 R3 R4 R5
    for (int v = 0; v < 8; v++) begin
      frame(VEC[v][29:14]);
      strobe();
      mdl[VEC[v][13:12]] = VEC[v][11:0];
      check_all("R2/R3/R4/R5 vector");
    end

    // R6: zero-scale clear visible before any clock edge
    @(negedge clk); clr_sel = 1'b0; clr_n = 1'b0; #1;
    set_all(12'h000);
    check_all("R6 async zero-scale");
    wait_n(5); clr_n = 1'b1; wait_n(6);
    check_all("R8 hold zero after release");
    strobe();
    mdl[2] = 12'h7E5;
    check_all("R8 restore held word");

    // R11: clr_sel moves while clear is inactive
    clr_sel = 1'b1; wait_n(6);
    check_all("R11 clr_sel ignored");
    clr_sel = 1'b0; wait_n(6);
    check_all("R11 clr_sel ignored back");

    // R7: clear in the middle of a frame
    cs_n = 1'b0; wait_n(3);
    send_bits(16'h4321, 8, 15);
    clr_sel = 1'b1; clr_n = 1'b0; #1;
    set_all(12'h800);
    check_all("R6 async midscale");
    wait_n(5); clr_n = 1'b1; wait_n(5);
    send_bits(16'h4321, 8, 7);
    cs_n = 1'b1; wait_n(3);
    strobe();
    mdl[1] = 12'h321;
    check_all("R7 frame survives clear");

    // Strobe and clear together: clear wins
    clr_sel = 1'b1; clr_n = 1'b0; wait_n(4);
    strobe();
    clr_n = 1'b1; wait_n(6);
    set_all(12'h800);
    check_all("R8 strobe under clear");
    strobe();
    mdl[1] = 12'h321;
    check_all("R8 strobe after clear");

    // R10: whole frame while strobe low
    ldac_n = 1'b0; wait_n(4);
    frame(16'hFAAA);
    ldac_n = 1'b1; wait_n(6);
    strobe();
    check_all("R10 frame during strobe ignored");

    // R9: chip select rises while sclk low
    spur = {16'h3555, 1'b1} >> 0;
    spur = {16'h3555 << 1} | 16'h0001;
    cs_n = 1'b0; wait_n(3);
    send_bits(16'h3555, 16, 15);
    sclk = 1'b0; sdin = 1'b1; wait_n(3);
    cs_n = 1'b1; wait_n(3);
    sclk = 1'b1; wait_n(3);
    strobe();
    mdl[spur[15:14]] = spur[11:0];
    check_all("R9 spurious bit");

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule